// File: doc/BRIEF.md
# Indirect Table Access Controller

This block is a register front end on a 32-bit host bus. It gives the host indirect access to two internal tables: a 32-entry scheme table whose entries are 23 words wide, and a 64-entry port table. Each port entry holds a scheme-partition word and a classification-plan-partition word. The tables are not in the host address map. The host reaches them through a shared staging window of 23 words at byte offset 0x100, and through one action register at byte offset 0x1FC.

To write an entry, the host fills the window and writes an action word with GO set and the direction bit clear. To read an entry, the host writes an action word with GO and the direction bit set, and the entry then appears in the window. In both cases the host polls the action register until GO reads 0, then checks the error bit. The transfer runs for a fixed number of cycles. During that time the action register ignores new commands.

A scheme image in the window holds 23 words. The block moves them as opaque data, except for window word 4, which is the scheme's packet counter. The other words carry the scheme's mode, the field-extraction command and the default-select word, 8 generic extraction commands, two default values, the two bit-mask words, the hash command, the queue base, the policer command, the coarse-classification bits, the match vector, the operation mode and the storage-profile word. For port transfers only window word 0 (scheme partition) and window word 1 (classification-plan partition) are used.

Top module: `tac_top`

## Requirements
- R1: After reset, the action register reads 0, every window word reads 0, and a read transfer of any table entry returns all zeros.
- R2: A write to the action register with bit 31 (GO) set, while idle, starts a transfer. GO then reads 1 for exactly XFER_CYCLES cycles (4 by default) and then reads 0.
- R3: A write to the action register while GO reads 1 is ignored. It starts no transfer, changes no table entry and leaves the action fields unchanged.
- R4: With table selector bits 25:24 = 00, the scheme index is taken from bits 23:16. When bit 30 is 0, the transfer copies the 23 window words into that entry. When bit 30 is 1, it copies the entry into the window.
- R5: On a scheme write, word 4 of the entry (the packet counter) is updated from the window only when bit 15 is set. Otherwise it keeps its old value.
- R6: With selector 10, the port index is taken from bits 7:0. Bit 15 selects the scheme-partition word (window word 0) and bit 14 selects the classification-plan word (window word 1), in both directions. A word that is not selected is left unchanged, in the table and in the window.
- R7: With selector 01, the transfer moves only the classification-plan word of the port at bits 7:0, through window word 1.
- R8: Bit 29 reads 1 after a transfer that had selector 11, a port index of 64 or more, or a scheme index of 32 or more. Such a transfer changes neither the tables nor the window. Each new accepted transfer clears bit 29.
- R9: Window word i is host readable and writable at byte offset 0x100 + 4·i. Unmapped offsets read 0.
- R10: When the action register is read, bits 30 and 28:0 return the fields of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 9 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from the address |

## Verification
A window write appears on the read port one clock edge after its strobe. GO reads 1 from the edge that takes the action write until XFER_CYCLES edges later. The table and window copy and the error bit all land on the same edge at which GO drops. The bench drives inputs and samples outputs on falling edges. It checks GO on each of the four falling edges after the start and again on the fifth. All other results are read only after polling has seen GO at 0, so each check falls after the copy edge.

// File: rtl/tac_pkg.sv
package tac_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 9;
    localparam int GO_BIT   = 31;
    localparam int DIR_BIT  = 30;
    localparam int ERR_BIT  = 29;
    localparam int SEL_LO   = 24;
    localparam int SIDX_LO  = 16;
    localparam int SEL_A    = 15;
    localparam int SEL_B    = 14;
    localparam int IDX_W    = 8;
    localparam int WIN_WORD = 64;   // byte 0x100
    localparam int ACT_WORD = 127;  // byte 0x1FC

    typedef enum logic [1:0] {
        TBL_SCHEME  = 2'b00,
        TBL_CLSPLAN = 2'b01,
        TBL_PORT    = 2'b10,
        TBL_NONE    = 2'b11
    } tbl_sel_e;

    typedef struct packed {
        logic             rd;
        tbl_sel_e         sel;
        logic [IDX_W-1:0] sch_idx;
        logic [IDX_W-1:0] port_idx;
        logic             sel_a;
        logic             sel_b;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.rd       = w[DIR_BIT];
        c.sel      = tbl_sel_e'(w[SEL_LO+1:SEL_LO]);
        c.sch_idx  = w[SIDX_LO+IDX_W-1:SIDX_LO];
        c.port_idx = w[IDX_W-1:0];
        c.sel_a    = w[SEL_A];
        c.sel_b    = w[SEL_B];
        return c;
    endfunction
endpackage

// File: rtl/tac_engine.sv
module tac_engine
    import tac_pkg::*;
#(
    parameter int XFER_CYCLES = 4,
    parameter int NUM_SCHEMES = 32,
    parameter int NUM_PORTS   = 64,
    localparam int CW  = $clog2(XFER_CYCLES + 1),
    localparam int SIW = $clog2(NUM_SCHEMES),
    localparam int PIW = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act_we,
    input  logic [DATA_W-1:0] act_wdata,
    output logic              busy,
    output logic              fire,
    output logic              bad,
    output logic              rd,
    output tbl_sel_e          sel,
    output logic              sel_a,
    output logic              sel_b,
    output logic [SIW-1:0]    sch_idx,
    output logic [PIW-1:0]    port_idx,
    output logic [DATA_W-1:0] act_rdata
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        ~((DATA_W'(1) << GO_BIT) | (DATA_W'(1) << ERR_BIT));

    logic              busy_q, bad_q, err_q;
    logic [CW-1:0]     cnt_q;
    logic [DATA_W-1:0] cmd_q;
    cmd_t              new_c, cur_c;
    logic              new_bad;

    assign new_c   = decode_cmd(act_wdata);
    assign new_bad = (new_c.sel == TBL_NONE) ||
                     (new_c.sel == TBL_SCHEME && int'(new_c.sch_idx) >= NUM_SCHEMES) ||
                     (new_c.sel != TBL_SCHEME && int'(new_c.port_idx) >= NUM_PORTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            bad_q  <= 1'b0;
            err_q  <= 1'b0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (!busy_q && act_we && act_wdata[GO_BIT]) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(XFER_CYCLES - 1);
            cmd_q  <= act_wdata & KEEP_MASK;
            bad_q  <= new_bad;
            err_q  <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                err_q  <= bad_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cur_c     = decode_cmd(cmd_q);
    assign busy      = busy_q;
    assign fire      = busy_q && (cnt_q == '0);
    assign bad       = bad_q;
    assign rd        = cur_c.rd;
    assign sel       = cur_c.sel;
    assign sel_a     = cur_c.sel_a;
    assign sel_b     = cur_c.sel_b;
    assign sch_idx   = cur_c.sch_idx[SIW-1:0];
    assign port_idx  = cur_c.port_idx[PIW-1:0];
    assign act_rdata = cmd_q | (DATA_W'(busy_q) << GO_BIT) | (DATA_W'(err_q) << ERR_BIT);
endmodule

// File: rtl/tac_window.sv
module tac_window
    import tac_pkg::*;
#(
    parameter int WORDS = 23,
    localparam int WIW = $clog2(WORDS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         host_we,
    input  logic [WIW-1:0]               host_idx,
    input  logic [DATA_W-1:0]            host_wdata,
    input  logic                         load_en,
    input  logic [WORDS-1:0]             load_mask,
    input  logic [WORDS-1:0][DATA_W-1:0] load_img,
    output logic [WORDS-1:0][DATA_W-1:0] img
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                img[w] <= '0;
            else if (load_en && load_mask[w])
                img[w] <= load_img[w];
            else if (host_we && int'(host_idx) == w)
                img[w] <= host_wdata;
        end
    end
endmodule

// File: rtl/tac_tables.sv
module tac_tables
    import tac_pkg::*;
#(
    parameter int NUM_SCHEMES = 32,
    parameter int NUM_PORTS   = 64,
    parameter int SCH_WORDS   = 23,
    localparam int SIW = $clog2(NUM_SCHEMES),
    localparam int PIW = $clog2(NUM_PORTS)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             sch_we,
    input  logic [SCH_WORDS-1:0]             sch_mask,
    input  logic [SIW-1:0]                   sch_idx,
    input  logic                             sp_we,
    input  logic                             cpp_we,
    input  logic [PIW-1:0]                   port_idx,
    input  logic [SCH_WORDS-1:0][DATA_W-1:0] win_img,
    output logic [SCH_WORDS-1:0][DATA_W-1:0] sch_rd,
    output logic [DATA_W-1:0]                sp_rd,
    output logic [DATA_W-1:0]                cpp_rd
);
    logic [SCH_WORDS-1:0][DATA_W-1:0] sch_q [NUM_SCHEMES];
    logic [DATA_W-1:0]                sp_q  [NUM_PORTS];
    logic [DATA_W-1:0]                cpp_q [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SCHEMES; s++) sch_q[s] <= '0;
        end else if (sch_we) begin
            for (int w = 0; w < SCH_WORDS; w++)
                if (sch_mask[w]) sch_q[sch_idx][w] <= win_img[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                sp_q[p]  <= '0;
                cpp_q[p] <= '0;
            end
        end else begin
            if (sp_we)  sp_q[port_idx]  <= win_img[0];
            if (cpp_we) cpp_q[port_idx] <= win_img[1];
        end
    end

    assign sch_rd = sch_q[sch_idx];
    assign sp_rd  = sp_q[port_idx];
    assign cpp_rd = cpp_q[port_idx];
endmodule

// File: rtl/tac_top.sv
module tac_top
    import tac_pkg::*;
#(
    parameter int NUM_SCHEMES = 32,
    parameter int NUM_PORTS   = 64,
    parameter int SCH_WORDS   = 23,
    parameter int CNT_WORD    = 4,
    parameter int XFER_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int SIW = $clog2(NUM_SCHEMES);
    localparam int PIW = $clog2(NUM_PORTS);
    localparam int WIW = $clog2(SCH_WORDS);
    localparam int AWW = ADDR_W - 2;

    logic [AWW-1:0] word;
    logic [AWW-1:0] win_off;
    logic           aligned, act_hit, win_hit, act_we, win_we;

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign win_off = word - AWW'(WIN_WORD);
    assign act_hit = aligned && (int'(word) == ACT_WORD);
    assign win_hit = aligned && (int'(word) >= WIN_WORD) && (int'(win_off) < SCH_WORDS);
    assign act_we  = bus_we && act_hit;
    assign win_we  = bus_we && win_hit;

    logic              busy, fire, bad, rd, sel_a, sel_b;
    tbl_sel_e          sel;
    logic [SIW-1:0]    sch_idx;
    logic [PIW-1:0]    port_idx;
    logic [DATA_W-1:0] act_rdata;

    tac_engine #(
        .XFER_CYCLES(XFER_CYCLES), .NUM_SCHEMES(NUM_SCHEMES), .NUM_PORTS(NUM_PORTS)
    ) u_engine (
        .clk(clk), .rst(rst), .act_we(act_we), .act_wdata(bus_wdata),
        .busy(busy), .fire(fire), .bad(bad), .rd(rd), .sel(sel),
        .sel_a(sel_a), .sel_b(sel_b), .sch_idx(sch_idx), .port_idx(port_idx),
        .act_rdata(act_rdata)
    );

    logic                             fire_ok, sch_we, sp_we, cpp_we, win_load;
    logic [SCH_WORDS-1:0]             sch_mask, load_mask;
    logic [SCH_WORDS-1:0][DATA_W-1:0] win_img, load_img, sch_rd;
    logic [DATA_W-1:0]                sp_rd, cpp_rd;

    assign fire_ok  = fire && !bad;
    assign sch_we   = fire_ok && !rd && (sel == TBL_SCHEME);
    assign sp_we    = fire_ok && !rd && (sel == TBL_PORT) && sel_a;
    assign cpp_we   = fire_ok && !rd &&
                      (((sel == TBL_PORT) && sel_b) || (sel == TBL_CLSPLAN));
    assign win_load = fire_ok && rd;

    always_comb begin
        sch_mask           = '1;
        sch_mask[CNT_WORD] = sel_a;
        load_mask          = '0;
        load_img           = '0;
        case (sel)
            TBL_SCHEME: begin
                load_mask = '1;
                load_img  = sch_rd;
            end
            TBL_PORT: begin
                load_mask[0] = sel_a;
                load_mask[1] = sel_b;
                load_img[0]  = sp_rd;
                load_img[1]  = cpp_rd;
            end
            TBL_CLSPLAN: begin
                load_mask[1] = 1'b1;
                load_img[1]  = cpp_rd;
            end
            default: ;
        endcase
    end

    tac_window #(.WORDS(SCH_WORDS)) u_window (
        .clk(clk), .rst(rst), .host_we(win_we), .host_idx(win_off[WIW-1:0]),
        .host_wdata(bus_wdata), .load_en(win_load), .load_mask(load_mask),
        .load_img(load_img), .img(win_img)
    );

    tac_tables #(
        .NUM_SCHEMES(NUM_SCHEMES), .NUM_PORTS(NUM_PORTS), .SCH_WORDS(SCH_WORDS)
    ) u_tables (
        .clk(clk), .rst(rst), .sch_we(sch_we), .sch_mask(sch_mask), .sch_idx(sch_idx),
        .sp_we(sp_we), .cpp_we(cpp_we), .port_idx(port_idx), .win_img(win_img),
        .sch_rd(sch_rd), .sp_rd(sp_rd), .cpp_rd(cpp_rd)
    );

    always_comb begin
        bus_rdata = '0;
        if (act_hit)
            bus_rdata = act_rdata;
        else if (win_hit)
            bus_rdata = win_img[win_off[WIW-1:0]];
    end
endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
    parameter int XFER_CYCLES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        fire,
    input logic        bad,
    input logic        act_we,
    input logic        any_update,
    input logic [31:0] act_rdata
);
    localparam int LW = $clog2(XFER_CYCLES + 2);
    logic [LW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_rdata == 32'h0)) else $error("reset state");   // R1
    AST_GO_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (int'(run_len) == XFER_CYCLES)) else $error("go length");   // R2
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && act_we && !fire) |=> $stable(act_rdata & 32'h5FFF_FFFF)) else $error("busy write");   // R3
    AST_BAD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (fire && bad) |-> !any_update) else $error("bad update");   // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !act_rdata[29]) else $error("err clear");   // R8
endmodule

bind tac_top tac_checker #(.XFER_CYCLES(XFER_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .fire(fire), .bad(bad), .act_we(act_we),
    .any_update(sch_we | sp_we | cpp_we | win_load), .act_rdata(act_rdata)
);

// File: tb/tac_top_test.sv
module tac_top_test;
    localparam int NS = 32, NP = 64, SW = 23, CW = 4;
    localparam logic [8:0]  ACT  = 9'h1FC;
    localparam logic [31:0] GO   = 32'h8000_0000, RDB = 32'h4000_0000;
    localparam logic [31:0] S_CP = 32'h0100_0000, S_PT = 32'h0200_0000, S_BAD = 32'h0300_0000;
    localparam logic [31:0] WA = 32'h0000_8000, WB = 32'h0000_4000;

    logic        clk = 0, rst = 1, bus_we = 0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    int tests = 0, fails = 0;
    bit done = 0;

    tac_top uut (.clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    always #10 clk = ~clk;

    function automatic logic [31:0] spat(int s, int w, int salt);
        return {8'(8'hA5 ^ s), 8'(w + salt), 16'(s * 37 + w * 11 + salt * 5)};
    endfunction
    function automatic logic [31:0] win(int i);
        return 32'(9'h100 + 9'(4 * i));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic xfer(logic [31:0] cmd);
        logic [31:0] v;
        wr(ACT, cmd);
        for (int k = 0; k < 40; k++) begin
            rd(ACT, v);
            if (!v[31]) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state, R9 unmapped reads
        rd(ACT, v);        check("R1 action", v, 0);
        rd(win(0), v);     check("R1 win0", v, 0);
        rd(win(22), v);    check("R1 win22", v, 0);
        rd(9'h000, v);     check("R9 unmapped", v, 0);
        rd(9'h160, v);     check("R9 past window", v, 0);
        xfer(GO | RDB | (32'd5 << 16));
        for (int w = 0; w < SW; w++) begin rd(win(w), v); check("R1 scheme zero", v, 0); end
        xfer(GO | RDB | S_PT | WA | WB | 32'd40);
        rd(win(0), v); check("R1 port sp zero", v, 0);
        rd(win(1), v); check("R1 port cpp zero", v, 0);
        // R9 window write/read
        wr(win(7), 32'hDEAD_BEEF); rd(win(7), v); check("R9 win rw", v, 32'hDEAD_BEEF);
        // R2 GO timing
        wr(ACT, GO | RDB | (32'd1 << 16));
        for (int k = 0; k < CW; k++) begin
            rd(ACT, v); check("R2 go high", 32'(v[31]), 1); @(negedge clk);
        end
        rd(ACT, v); check("R2 go low", 32'(v[31]), 0);
        // R4 scheme sweep write
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < SW; w++) wr(win(w), spat(s, w, 0));
            c = GO | WA | (32'(s) << 16);
            xfer(c);
            rd(ACT, v); check("R10 fields", v, c & 32'h5FFF_FFFF);
        end
        for (int s = NS - 1; s >= 0; s--) begin
            c = GO | RDB | (32'(s) << 16);
            xfer(c);
            rd(ACT, v); check("R10 read fields", v, c & 32'h5FFF_FFFF);
            for (int w = 0; w < SW; w++) begin rd(win(w), v); check("R4 scheme rt", v, spat(s, w, 0)); end
        end
        // R5 counter word held without bit 15
        for (int w = 0; w < SW; w++) wr(win(w), spat(3, w, 9));
        xfer(GO | (32'd3 << 16));
        xfer(GO | RDB | (32'd3 << 16));
        for (int w = 0; w < SW; w++) begin
            rd(win(w), v); check("R5 counter hold", v, (w == 4) ? spat(3, w, 0) : spat(3, w, 9));
        end
        // R6 port sweep
        for (int p = 0; p < NP; p++) begin
            wr(win(0), spat(p, 0, 3)); wr(win(1), spat(p, 1, 4));
            xfer(GO | S_PT | WA | WB | 32'(p));
        end
        for (int p = 0; p < NP; p++) begin
            xfer(GO | RDB | S_PT | WA | WB | 32'(p));
            rd(win(0), v); check("R6 sp rt", v, spat(p, 0, 3));
            rd(win(1), v); check("R6 cpp rt", v, spat(p, 1, 4));
        end
        wr(win(0), 32'h1111_0000); wr(win(1), 32'h2222_0000);
        xfer(GO | S_PT | WA | 32'd9);
        xfer(GO | RDB | S_PT | WA | WB | 32'd9);
        rd(win(0), v); check("R6 sp only write", v, 32'h1111_0000);
        rd(win(1), v); check("R6 cpp untouched", v, spat(9, 1, 4));
        wr(win(0), 32'h7777_7777);
        xfer(GO | RDB | S_PT | WB | 32'd10);
        rd(win(0), v); check("R6 window unselected", v, 32'h7777_7777);
        rd(win(1), v); check("R6 cpp only read", v, spat(10, 1, 4));
        // R7 classification-plan selector
        wr(win(0), 32'h0BAD_0BAD); wr(win(1), 32'h00C0_FFEE);
        xfer(GO | S_CP | 32'd12);
        xfer(GO | RDB | S_PT | WA | WB | 32'd12);
        rd(win(0), v); check("R7 sp kept", v, spat(12, 0, 3));
        rd(win(1), v); check("R7 cpp written", v, 32'h00C0_FFEE);
        // R8 errors
        wr(win(0), 32'hEEEE_0001); wr(win(1), 32'hEEEE_0002);
        xfer(GO | S_PT | WA | WB | 32'd64);
        rd(ACT, v); check("R8 port 64 err", 32'(v[29]), 1);
        xfer(GO | RDB | S_BAD | 32'd1);
        rd(ACT, v); check("R8 sel 11 err", 32'(v[29]), 1);
        rd(win(0), v); check("R8 window kept", v, 32'hEEEE_0001);
        xfer(GO | (32'd32 << 16));
        rd(ACT, v); check("R8 scheme 32 err", 32'(v[29]), 1);
        xfer(GO | RDB | (32'd0 << 16));
        rd(ACT, v); check("R8 err cleared", 32'(v[29]), 0);
        rd(win(0), v); check("R8 scheme0 kept", v, spat(0, 0, 0));
        xfer(GO | RDB | S_PT | WA | WB | 32'd63);
        rd(win(0), v); check("R8 port63 kept", v, spat(63, 0, 3));
        // R3 write while busy ignored
        for (int w = 0; w < SW; w++) wr(win(w), spat(6, w, 7));
        wr(ACT, GO | RDB | (32'd2 << 16));
        wr(ACT, GO | WA | (32'd6 << 16));
        for (int k = 0; k < 40; k++) begin rd(ACT, v); if (!v[31]) break; @(negedge clk); end
        rd(ACT, v); check("R3 fields kept", v, (GO | RDB | (32'd2 << 16)) & 32'h5FFF_FFFF);
        rd(win(5), v); check("R3 first cmd done", v, spat(2, 5, 0));
        xfer(GO | RDB | (32'd6 << 16));
        rd(win(5), v); check("R3 scheme6 unchanged", v, spat(6, 5, 0));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule